// File: doc/BRIEF.md
# Pin Function Multiplexer with Input Priority

This block sits between twelve port pins and a fixed set of on-chip peripheral signals. For each pin a small mode register, reached through the same byte-addressed register bus as the port data registers, selects a function code and a two-bit direction/pull field. From these it works out the pin's output enable, its output value and its pull-up and pull-down enables. It also steers pin levels back to the peripheral inputs.

Function code 0 is plain GPIO. In that mode the pull field sets the direction, and the output value comes from the port data register. The other codes either give the pin to a peripheral output or make it the source of a peripheral input. The two I2C lines work as open-drain lines in both directions. Diagnostic lanes can be shown on the lowest pins and, as a mirror, on the highest pins. ADC selection is only flagged on the pins that support it.

When several pins claim the same peripheral input, the lowest-numbered pin supplies it. An input that no pin claims sits at its idle level.

Top module: `pin_function_mux`

## Requirements
- R1: After reset every mode register reads 0. Every pin is then a GPIO input with no pull: pin_oe, pin_do, pin_pu, pin_pd and adc_en are all 0, and per_in equals its idle value.
- R2: The mode register for pin n sits at byte offset 0x6 + 2n. Bits [4:0] hold the function code and bits [9:8] hold the pull field. All other bits read 0. Reads of any other offset return 0. A write to any other offset changes no mode register.
- R3: With code 0 (GPIO) the pull field works as follows. 00 is an input with no pull, 01 an input with pull-up, 10 an input with pull-down, and 11 an output. pin_do follows gpio_do only while the pin is an output.
- R4: Codes 2, 4, 5, 6, 11, 12, 13, 16, 17, 20, 23, 24, 25, 27, 28, 29 and 30 are output functions. The pin sets pin_oe=1, drives pin_do = per_drv[code] and enables no pull.
- R5: Codes 1, 3, 19 and 26 are input functions. The pin sets pin_oe=0, takes its pull from the field (11 gives no pull), and its pin_in level appears on per_in[code].
- R6: When more than one pin requests the same input code, per_in[code] takes the level of the lowest-numbered requesting pin.
- R7: A per_in bit that no pin requests holds its idle value. Bits 1, 3, 19 and 26 idle at 1. All other bits idle at 0, and that includes every code that is not an input.
- R8: Codes 9 and 10 are open-drain I2C lines. pin_oe = NOT per_drv[code] and pin_do = 0. The pull comes from the field as for inputs, and pin_in is routed to per_in[code] with the priority of R6.
- R9: Code 18 (diagnostic) on pins 0–3 drives diag_drv[n]. On pins 8–11 it drives diag_drv[n-8]. On pins 4–7 the code behaves as reserved (R11).
- R10: Code 15 on pins 1, 2, 6 and 7 sets adc_en[n]=1 with pin_oe=0 and no pull, whatever the pull field holds. On any other pin it behaves as reserved.
- R11: Reserved codes 7, 8, 14, 21, 22 and 31 give no output enable, no pull, no adc_en and no input routing. The same holds for a diagnostic or ADC code on a pin that does not support it.
- R12: pin_pu and pin_pd are never 1 together. pin_do is 0 whenever pin_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| gpio_do | input | 12 | Output values from the port data register |
| per_drv | input | 32 | Peripheral output signal, indexed by function code |
| diag_drv | input | 4 | Diagnostic lanes |
| pin_in | input | 12 | Levels sensed at the pins |
| pin_oe | output | 12 | Pin output enable |
| pin_do | output | 12 | Pin output value |
| pin_pu | output | 12 | Pull-up enable |
| pin_pd | output | 12 | Pull-down enable |
| adc_en | output | 12 | Pin handed to the analog converter |
| per_in | output | 32 | Routed peripheral input, indexed by function code |

## Verification
The bench builds the block with its defaults. That means twelve pins, four diagnostic lanes (so both the low set of lanes and the mirrored high set exist) and an ADC mask that leaves eight pins unable to take ADC mode. With these values the first and last register offsets (0x06 and 0x1C) and the offsets just outside them can be checked. Priority can be checked between widely separated pins, and a diagnostic code can be placed on a pin in the middle band that must stay quiet. Random mode sets over all 32 codes often produce several claimants for the same input, which exercises the priority chain from many starting points.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

    localparam int CODE_W = 5;
    localparam int NCODES = 1 << CODE_W;

    localparam logic [CODE_W-1:0] CODE_GPIO = 5'd0;
    localparam logic [CODE_W-1:0] CODE_ADC  = 5'd15;
    localparam logic [CODE_W-1:0] CODE_DIAG = 5'd18;

    // peripheral outputs driven straight onto a pin
    localparam logic [NCODES-1:0] OUT_CODES =
        (32'd1 << 2)  | (32'd1 << 4)  | (32'd1 << 5)  | (32'd1 << 6)  |
        (32'd1 << 11) | (32'd1 << 12) | (32'd1 << 13) | (32'd1 << 16) |
        (32'd1 << 17) | (32'd1 << 20) | (32'd1 << 23) | (32'd1 << 24) |
        (32'd1 << 25) | (32'd1 << 27) | (32'd1 << 28) | (32'd1 << 29) |
        (32'd1 << 30);

    // peripheral inputs fed from a pin
    localparam logic [NCODES-1:0] IN_CODES =
        (32'd1 << 1) | (32'd1 << 3) | (32'd1 << 19) | (32'd1 << 26);

    // open-drain bidirectional lines
    localparam logic [NCODES-1:0] OD_CODES = (32'd1 << 9) | (32'd1 << 10);

    // idle level of every routed input: the active-low or mark-idle ones sit high
    localparam logic [NCODES-1:0] IDLE_VAL = IN_CODES;

    localparam logic [NCODES-1:0] RSV_CODES =
        (32'd1 << 7) | (32'd1 << 8) | (32'd1 << 14) |
        (32'd1 << 21) | (32'd1 << 22) | (32'd1 << 31);

    typedef enum logic [2:0] {
        K_NONE,
        K_GPIO,
        K_OUT,
        K_IN,
        K_OD,
        K_DIAG,
        K_ADC
    } pin_kind_e;

endpackage

// File: rtl/pfm_mode_regs.sv
module pfm_mode_regs
    import pfm_pkg::*;
#(
    parameter int NPINS    = 12,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int BASE_OFF = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic [NPINS-1:0][CODE_W-1:0]  code_q,
    output logic [NPINS-1:0][1:0]         pull_q
);

    localparam int PULL_LSB = 8;

    logic [NPINS-1:0] hit;

    for (genvar n = 0; n < NPINS; n++) begin : g_reg
        localparam logic [ADDR_W-1:0] OFF = ADDR_W'(BASE_OFF + 2 * n);

        assign hit[n] = (bus_addr == OFF);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q[n] <= '0;
                pull_q[n] <= '0;
            end else if (bus_wr && hit[n]) begin
                code_q[n] <= bus_wdata[CODE_W-1:0];
                pull_q[n] <= bus_wdata[PULL_LSB +: 2];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NPINS; n++) begin
            if (hit[n]) begin
                bus_rdata[CODE_W-1:0]     = code_q[n];
                bus_rdata[PULL_LSB +: 2]  = pull_q[n];
            end
        end
    end

    // a write that misses every mode register leaves all of them untouched
    assert_stray_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit == '0) |=> ($stable(code_q) && $stable(pull_q)));

endmodule

// File: rtl/pfm_pin_cell.sv
module pfm_pin_cell
    import pfm_pkg::*;
#(
    parameter int NPINS     = 12,
    parameter int PIN       = 0,
    parameter int DIAG_W    = 4,
    parameter bit ADC_OK    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic [1:0]        pull,
    input  logic              gpio_do,
    input  logic [NCODES-1:0] per_drv,
    input  logic [DIAG_W-1:0] diag_drv,
    output logic              oe,
    output logic              dout,
    output logic              pu,
    output logic              pd,
    output logic              adc_en,
    output logic              in_req
);

    localparam bit DIAG_LOW  = (PIN < DIAG_W);
    localparam bit DIAG_HIGH = (PIN >= NPINS - DIAG_W);
    localparam bit DIAG_OK   = DIAG_LOW || DIAG_HIGH;
    localparam int DIAG_IDX  = DIAG_LOW ? PIN : (DIAG_HIGH ? PIN - (NPINS - DIAG_W) : 0);

    pin_kind_e kind;

    always_comb begin
        kind = K_NONE;
        if (code == CODE_GPIO)                  kind = K_GPIO;
        else if (OUT_CODES[code])               kind = K_OUT;
        else if (IN_CODES[code])                kind = K_IN;
        else if (OD_CODES[code])                kind = K_OD;
        else if (code == CODE_DIAG && DIAG_OK)  kind = K_DIAG;
        else if (code == CODE_ADC && ADC_OK)    kind = K_ADC;
    end

    always_comb begin
        oe     = 1'b0;
        dout   = 1'b0;
        pu     = 1'b0;
        pd     = 1'b0;
        adc_en = 1'b0;
        in_req = 1'b0;
        unique case (kind)
            K_GPIO: begin
                oe   = (pull == 2'b11);
                dout = (pull == 2'b11) & gpio_do;
                pu   = (pull == 2'b01);
                pd   = (pull == 2'b10);
            end
            K_OUT: begin
                oe   = 1'b1;
                dout = per_drv[code];
            end
            K_IN: begin
                pu     = (pull == 2'b01);
                pd     = (pull == 2'b10);
                in_req = 1'b1;
            end
            K_OD: begin
                oe     = ~per_drv[code];
                pu     = (pull == 2'b01);
                pd     = (pull == 2'b10);
                in_req = 1'b1;
            end
            K_DIAG: begin
                oe   = 1'b1;
                dout = diag_drv[DIAG_IDX];
            end
            K_ADC: begin
                adc_en = 1'b1;
            end
            K_NONE: begin
            end
            default: begin
            end
        endcase
    end

    assert_no_dual_pull_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(pu && pd));

    assert_quiet_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !dout);

    assert_reserved_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        RSV_CODES[code] |-> (!oe && !pu && !pd && !in_req && !adc_en));

    assert_out_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        OUT_CODES[code] |-> (oe && dout == per_drv[code] && !pu && !pd));

    assert_adc_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (code == CODE_ADC) |-> (!oe && !pu && !pd && !in_req));

endmodule

// File: rtl/pfm_in_arb.sv
module pfm_in_arb
    import pfm_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPINS-1:0][CODE_W-1:0]  code,
    input  logic [NPINS-1:0]              in_req,
    input  logic [NPINS-1:0]              pin_in,
    output logic [NCODES-1:0]             per_in
);

    for (genvar c = 0; c < NCODES; c++) begin : g_code
        logic val;

        // scan from the top so the lowest requesting pin is applied last
        always_comb begin
            val = IDLE_VAL[c];
            for (int n = NPINS - 1; n >= 0; n--) begin
                if (in_req[n] && code[n] == CODE_W'(c)) val = pin_in[n];
            end
        end

        assign per_in[c] = val;
    end

    assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_req[0] |-> (per_in[code[0]] == pin_in[0]));

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req == '0) |-> (per_in == IDLE_VAL));

endmodule

// File: rtl/pin_function_mux.sv
module pin_function_mux
    import pfm_pkg::*;
#(
    parameter int               NPINS    = 12,
    parameter int               ADDR_W   = 8,
    parameter int               DATA_W   = 16,
    parameter int               BASE_OFF = 6,
    parameter int               DIAG_W   = 4,
    parameter logic [NPINS-1:0] ADC_MASK = 12'h0C6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  gpio_do,
    input  logic [NCODES-1:0] per_drv,
    input  logic [DIAG_W-1:0] diag_drv,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_do,
    output logic [NPINS-1:0]  pin_pu,
    output logic [NPINS-1:0]  pin_pd,
    output logic [NPINS-1:0]  adc_en,
    output logic [NCODES-1:0] per_in
);

    logic [NPINS-1:0][CODE_W-1:0] code_q;
    logic [NPINS-1:0][1:0]        pull_q;
    logic [NPINS-1:0]             in_req;

    pfm_mode_regs #(
        .NPINS    (NPINS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .BASE_OFF (BASE_OFF)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .code_q    (code_q),
        .pull_q    (pull_q)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        pfm_pin_cell #(
            .NPINS  (NPINS),
            .PIN    (n),
            .DIAG_W (DIAG_W),
            .ADC_OK (ADC_MASK[n])
        ) cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .code     (code_q[n]),
            .pull     (pull_q[n]),
            .gpio_do  (gpio_do[n]),
            .per_drv  (per_drv),
            .diag_drv (diag_drv),
            .oe       (pin_oe[n]),
            .dout     (pin_do[n]),
            .pu       (pin_pu[n]),
            .pd       (pin_pd[n]),
            .adc_en   (adc_en[n]),
            .in_req   (in_req[n])
        );
    end

    pfm_in_arb #(
        .NPINS (NPINS)
    ) arb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .code   (code_q),
        .in_req (in_req),
        .pin_in (pin_in),
        .per_in (per_in)
    );

endmodule

// File: tb/pin_function_mux_tb.sv
module pin_function_mux_tb_top;
    import pfm_pkg::*;

    localparam int NP = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NP-1:0] gpio_do = '0;
    logic [31:0] per_drv = '0;
    logic [3:0]  diag_drv = '0;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_oe, pin_do, pin_pu, pin_pd, adc_en;
    logic [31:0] per_in;

    always #10 clk = ~clk;

    pin_function_mux dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_do(gpio_do),
        .per_drv(per_drv), .diag_drv(diag_drv), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_do(pin_do), .pin_pu(pin_pu), .pin_pd(pin_pd),
        .adc_en(adc_en), .per_in(per_in)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 1'b0;

    logic [4:0] m_code [NP];
    logic [1:0] m_pull [NP];
    logic [NP-1:0] e_oe, e_do, e_pu, e_pd, e_adc;
    logic [31:0] e_in;

    localparam logic [31:0] T_OUT = 32'h7B93_3874; // codes 2,4,5,6,11-13,16,17,20,23-25,27-30
    localparam logic [31:0] T_IN  = 32'h0408_000A; // codes 1,3,19,26
    localparam logic [11:0] T_ADC = 12'h0C6;        // pins 1,2,6,7

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic predict();
        e_oe = '0; e_do = '0; e_pu = '0; e_pd = '0; e_adc = '0;
        e_in = T_IN;
        for (int n = NP - 1; n >= 0; n--) begin
            logic [4:0] c;
            logic [1:0] p;
            c = m_code[n];
            p = m_pull[n];
            if (c == 5'd0) begin
                e_oe[n] = (p == 2'd3);
                e_do[n] = (p == 2'd3) & gpio_do[n];
                e_pu[n] = (p == 2'd1);
                e_pd[n] = (p == 2'd2);
            end else if (T_OUT[c]) begin
                e_oe[n] = 1'b1;
                e_do[n] = per_drv[c];
            end else if (T_IN[c] || c == 5'd9 || c == 5'd10) begin
                e_pu[n] = (p == 2'd1);
                e_pd[n] = (p == 2'd2);
                e_in[c] = pin_in[n];
                if (c == 5'd9 || c == 5'd10) e_oe[n] = ~per_drv[c];
            end else if (c == 5'd18 && (n < 4 || n >= 8)) begin
                e_oe[n] = 1'b1;
                e_do[n] = diag_drv[(n < 4) ? n : n - 8];
            end else if (c == 5'd15 && T_ADC[n]) begin
                e_adc[n] = 1'b1;
            end
        end
    endtask

    task automatic check_all(string req);
        #1;
        predict();
        cmp(req, "pin_oe", 32'(pin_oe), 32'(e_oe));
        cmp(req, "pin_do", 32'(pin_do), 32'(e_do));
        cmp(req, "pin_pu", 32'(pin_pu), 32'(e_pu));
        cmp(req, "pin_pd", 32'(pin_pd), 32'(e_pd));
        cmp(req, "adc_en", 32'(adc_en), 32'(e_adc));
        cmp(req, "per_in", per_in, e_in);
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a >= 8'h06 && a <= 8'h1C && a[0] == 1'b0) begin
            m_code[(a - 8'h06) >> 1] = d[4:0];
            m_pull[(a - 8'h06) >> 1] = d[9:8];
        end
    endtask

    task automatic set_mode(int n, logic [4:0] c, logic [1:0] p);
        wr(8'(6 + 2 * n), {6'd0, p, 3'd0, c});
    endtask

    task automatic rd_check(string req, logic [7:0] a, logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        cmp(req, $sformatf("read @%h", a), 32'(bus_rdata), 32'(exp));
    endtask

    task automatic all_gpio();
        for (int n = 0; n < NP; n++) set_mode(n, 5'd0, 2'd0);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int n = 0; n < NP; n++) begin m_code[n] = '0; m_pull[n] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        gpio_do = 12'hFFF; per_drv = 32'hFFFF_FFFF; diag_drv = 4'hF; pin_in = 12'h5A5;
        check_all("R1");
        for (int n = 0; n < NP; n++) rd_check("R1", 8'(6 + 2 * n), 16'h0000);

        // R2: field packing, stray offsets
        wr(8'h06 + 8'd6, 16'hFFFF);               // pin 3: code 31 reserved, pull 11
        rd_check("R2", 8'h0C, 16'h031F);
        check_all("R11");
        wr(8'h04, 16'hFFFF);
        wr(8'h1E, 16'hFFFF);
        wr(8'h07, 16'hFFFF);
        for (int n = 0; n < NP; n++)
            rd_check("R2", 8'(6 + 2 * n), (n == 3) ? 16'h031F : 16'h0000);
        rd_check("R2", 8'h1E, 16'h0000);
        rd_check("R2", 8'h04, 16'h0000);

        // R3: GPIO pull field
        set_mode(0, 5'd0, 2'd0); set_mode(1, 5'd0, 2'd1);
        set_mode(2, 5'd0, 2'd2); set_mode(3, 5'd0, 2'd3);
        gpio_do = 12'h00F;
        check_all("R3");
        gpio_do = 12'h000;
        check_all("R3");

        // R4: peripheral outputs
        set_mode(5, 5'd2, 2'd1); set_mode(6, 5'd28, 2'd2); set_mode(11, 5'd30, 2'd0);
        per_drv = 32'h1000_0004;
        check_all("R4");
        per_drv = 32'h4000_0000;
        check_all("R4");

        // R5 / R6: input routing and priority (pins 2 and 7 both claim code 26)
        set_mode(7, 5'd26, 2'd1); set_mode(2, 5'd26, 2'd2);
        pin_in = 12'h080;
        check_all("R5");
        cmp("R6", "per_in[26] low pin wins", 32'(per_in[26]), 32'd0);
        pin_in = 12'h004;
        check_all("R6");
        cmp("R6", "per_in[26] low pin wins", 32'(per_in[26]), 32'd1);

        // R7: idle values
        all_gpio();
        pin_in = 12'h000;
        check_all("R7");
        cmp("R7", "per_in idle", per_in, 32'h0408_000A);

        // R8: open-drain I2C on pin 10
        set_mode(10, 5'd9, 2'd1);
        per_drv = 32'h0000_0000; pin_in = 12'h400;
        check_all("R8");
        cmp("R8", "oe when peripheral drives low", 32'(pin_oe[10]), 32'd1);
        per_drv = 32'h0000_0200;
        check_all("R8");

        // R9: diagnostic lanes, mirrored and middle band
        set_mode(9, 5'd18, 2'd0); set_mode(1, 5'd18, 2'd0); set_mode(5, 5'd18, 2'd3);
        diag_drv = 4'b0010;
        check_all("R9");
        cmp("R9", "pin 9 mirrors lane 1", 32'(pin_do[9]), 32'd1);
        cmp("R9", "pin 5 quiet", 32'(pin_oe[5]), 32'd0);
        diag_drv = 4'b1101;
        check_all("R9");

        // R10 / R11: ADC on capable and incapable pins, reserved codes
        all_gpio();
        set_mode(6, 5'd15, 2'd3); set_mode(0, 5'd15, 2'd1);
        set_mode(4, 5'd7, 2'd1);  set_mode(8, 5'd22, 2'd2);
        check_all("R10");
        cmp("R10", "adc_en", 32'(adc_en), 32'h040);
        check_all("R11");

        // random mode sets mixed with random inputs (R3-R12 together)
        for (int it = 0; it < 60; it++) begin
            for (int n = 0; n < NP; n++) begin
                logic [31:0] r;
                r = $urandom;
                // bias toward input codes so priority contention is frequent
                if (r[31:30] == 2'b00) set_mode(n, (r[8]) ? 5'd26 : 5'd9, r[13:12]);
                else set_mode(n, r[4:0], r[13:12]);
            end
            gpio_do = 12'($urandom); per_drv = $urandom;
            diag_drv = 4'($urandom); pin_in = 12'($urandom);
            check_all("R12");
            cmp("R12", "no dual pull", 32'(pin_pu & pin_pd), 32'd0);
        end

        report();
    end

endmodule